// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked single-port static memory of 2**ADDR_W words of DATA_W bits (a 14-bit address with 8-bit data gives the full 16K x 8 organisation; the default build uses a smaller array). Every control input is sampled on the rising clock edge: address, write enable, chip select and write data all land in input registers together. The array access is then made from those registered values, so a caller presents one complete operation per clock.

A burst input lets one captured address serve up to four accesses. While it is held high, the block ignores the external address. Instead it steps the two low bits of the registered address by one on every clock, wrapping inside the aligned group of four, while the upper bits stay put. Write enable, chip select and write data are still sampled on every beat, so a burst may read or write. Dropping the burst input loads a fresh external address and ends the burst.

The `PIPELINED` parameter selects the read path. When it is set, array data goes through an output register and appears one clock later. When it is clear, data flows from the array to the outputs combinationally. An output-enable input gates the data outputs. Their drive-enable output tells the pad ring when to drive the shared data lines.

Top module: `sburst_sram`

## Requirements
- R1: Address, write enable, chip select and write data are sampled only on the rising clock edge; the access uses the sampled values, not the live inputs.
- R2: An operation sampled with chip select and write enable both high stores the sampled write data at the sampled address.
- R3: With `PIPELINED`=0, a read sampled at edge k shows the addressed word on `dout_o` from just after edge k until edge k+1.
- R4: With `PIPELINED`=1, a read sampled at edge k shows the addressed word on `dout_o` from just after edge k+1 until edge k+2.
- R5: With `burst_i` high at an edge, the registered address keeps bits [ADDR_W-1:2] and increments bits [1:0] by one modulo 4. Base 0x7A0 gives 0x7A0, 0x7A1, 0x7A2, 0x7A3, and start offset 2 gives offsets 2, 3, 0, 1.
- R6: While `burst_i` is high, the value on `addr_i` has no effect on which word is accessed.
- R7: With `burst_i` low at an edge, `addr_i` is loaded as the new registered address, ending any burst in progress.
- R8: A burst beat sampled with write enable and chip select high writes that beat's sampled data to the current burst address.
- R9: `dout_en_o` is high only when `oe_i` is high and the read path holds a read result (a sampled read with chip select high and write enable low, delayed per R3/R4). Whenever `dout_en_o` is low, `dout_o` is all zeros.
- R10: After reset, `dout_en_o` is low and `dout_o` is zero until a read is sampled.
- R11: An operation sampled with chip select low neither writes the array nor produces read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | External word address |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write enable, active high |
| burst_i | input | 1 | High: advance the burst address instead of loading `addr_i` |
| oe_i | input | 1 | Output enable, active high |
| wdata_i | input | DATA_W | Write data |
| dout_o | output | DATA_W | Read data, zero when not driven |
| dout_en_o | output | 1 | High when the data lines should be driven |

## Verification
A burst step and a write can fall in the same clock. The address advance and the array store then both depend on registered state from the edge before, and a store to the wrong beat address would only show up on a later read. The bench provokes this with directed write bursts, driving random junk on `addr_i`. It then reads the group back with a different start offset so the wrap is exercised, and mixes burst and write cycles densely in the random phase. A write sampled one cycle before a read of the same word also tests the array's store edge against the read path. Both read-path variants run side by side against one reference array, and every read is judged at the cycle derived from R3 or R4.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef struct packed {
    logic cs;
    logic we;
  } sbs_ctl_t;

  function automatic logic [BEAT_W-1:0] sbs_next_beat(input logic [BEAT_W-1:0] cur);
    return cur + {{(BEAT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sbs_capture.sv
module sbs_capture
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              burst_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_q,
  output sbs_ctl_t          ctl_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] addr_d;
  sbs_ctl_t          ctl_d;

  // next-state: burst steps the low bits inside the aligned group
  always_comb begin
    if (burst_i) begin
      addr_d = {addr_q[ADDR_W-1:BEAT_W], sbs_next_beat(addr_q[BEAT_W-1:0])};
    end else begin
      addr_d = addr_i;
    end
    ctl_d.cs = cs_i;
    ctl_d.we = we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctl_q  <= '0;
    end else begin
      addr_q <= addr_d;
      ctl_q  <= ctl_d;
    end
  end

  // data register needs no reset: it is only consumed under a reset-qualified write
  always_ff @(posedge clk) begin
    wdata_q <= wdata_i;
  end

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sbs_read_path.sv
module sbs_read_path #(
  parameter int unsigned DATA_W    = 8,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic              have_data;
  logic [DATA_W-1:0] path_data;

  generate
    if (PIPELINED) begin : g_reg
      logic              valid_d;
      logic              valid_q;
      logic              load_en;
      logic [DATA_W-1:0] data_q;

      always_comb begin
        valid_d = rd_req;
        load_en = rd_req;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
        end else begin
          valid_q <= valid_d;
        end
      end

      always_ff @(posedge clk) begin
        if (load_en) begin
          data_q <= arr_data;
        end
      end

      assign have_data = valid_q;
      assign path_data = data_q;
    end else begin : g_flow
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign have_data  = rd_req;
      assign path_data  = arr_data;
    end
  endgenerate

  always_comb begin
    dout_en_o = oe_i & have_data;
    dout_o    = dout_en_o ? path_data : '0;
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              burst_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  sbs_ctl_t          ctl_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] arr_rdata;
  logic              wr_en;
  logic              rd_req;

  sbs_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sbs_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr_i (addr_i),
    .cs_i   (cs_i),
    .we_i   (we_i),
    .burst_i(burst_i),
    .wdata_i(wdata_i),
    .addr_q (addr_q),
    .ctl_q  (ctl_q),
    .wdata_q(wdata_q)
  );

  always_comb begin
    wr_en  = ctl_q.cs & ctl_q.we;
    rd_req = ctl_q.cs & ~ctl_q.we;
  end

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .wr_en(wr_en),
    .addr (addr_q),
    .wdata(wdata_q),
    .rdata(arr_rdata)
  );

  sbs_read_path #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_read_path (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .arr_data (arr_rdata),
    .oe_i     (oe_i),
    .dout_o   (dout_o),
    .dout_en_o(dout_en_o)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter bit          PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              burst_i,
  input logic              oe_i,
  input logic [ADDR_W-1:0] addr_q,
  input logic              cs_q,
  input logic              we_q,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o
);
  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> addr_q[1:0] == $past(addr_q[1:0]) + 2'd1);

  assert_burst_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]));

  assert_new_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_i |=> addr_q == $past(addr_i));

  assert_drive_needs_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en_o |-> oe_i);

  assert_quiet_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en_o |-> dout_o == '0);

  generate
    if (PIPELINED) begin : g_pipe
      assert_pipe_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en_o |-> $past(cs_q && !we_q));
    end else begin : g_flow
      assert_flow_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en_o |-> (cs_q && !we_q));
    end
  endgenerate
endmodule

bind sburst_sram sbs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPELINED(PIPELINED)
) u_sbs_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .addr_i   (addr_i),
  .burst_i  (burst_i),
  .oe_i     (oe_i),
  .addr_q   (addr_q),
  .cs_q     (ctl_q.cs),
  .we_q     (ctl_q.we),
  .dout_o   (dout_o),
  .dout_en_o(dout_en_o)
);

// File: tb/sburst_sram_bench.sv
`timescale 1ns/1ps
module sburst_sram_bench;
  localparam int unsigned AW    = 11;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs, we, burst, oe;
  logic [DW-1:0] wdata;
  logic [DW-1:0] dout_p, dout_f;
  logic          en_p, en_f;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R1";

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_ok  [DEPTH];
  logic [AW-1:0] m_addr;
  logic          m_we, m_cs;
  logic [DW-1:0] m_wd;
  logic          p_valid;
  logic [DW-1:0] p_data;
  bit            p_known;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sburst_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1)) u_sburst_sram (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_i(cs), .we_i(we),
    .burst_i(burst), .oe_i(oe), .wdata_i(wdata), .dout_o(dout_p), .dout_en_o(en_p)
  );

  sburst_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0)) u_sburst_sram_flow (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_i(cs), .we_i(we),
    .burst_i(burst), .oe_i(oe), .wdata_i(wdata), .dout_o(dout_f), .dout_en_o(en_f)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // sampled at the falling edge, inputs unchanged since the previous falling edge
  task automatic check_outputs();
    logic fexp;
    logic pexp;
    fexp = oe && m_cs && !m_we;
    check("R9 flow enable", {7'd0, en_f}, {7'd0, fexp});
    if (fexp && ref_ok[m_addr]) check({cur_tag, " R3 flow data"}, dout_f, ref_mem[m_addr]);
    if (!fexp) check("R9 flow idle data", dout_f, '0);
    pexp = oe && p_valid;
    check("R9 pipe enable", {7'd0, en_p}, {7'd0, pexp});
    if (pexp && p_known) check({cur_tag, " R4 pipe data"}, dout_p, p_data);
    if (!pexp) check("R9 pipe idle data", dout_p, '0);
  endtask

  task automatic model_edge();
    if (m_cs && m_we) begin
      ref_mem[m_addr] = m_wd;
      ref_ok[m_addr]  = 1'b1;
    end
    if (m_cs && !m_we) begin
      p_data  = ref_mem[m_addr];
      p_known = ref_ok[m_addr];
    end
    p_valid = m_cs && !m_we;
    m_addr  = burst ? {m_addr[AW-1:2], m_addr[1:0] + 2'd1} : addr;
    m_we    = we;
    m_cs    = cs;
    m_wd    = wdata;
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic c, input logic w,
                     input logic o, input logic b, input logic [DW-1:0] d);
    @(negedge clk);
    check_outputs();
    addr = a; cs = c; we = w; oe = o; burst = b; wdata = d;
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
    m_addr = '0; m_we = 1'b0; m_cs = 1'b0; m_wd = '0;
    p_valid = 1'b0; p_data = '0; p_known = 1'b0;
    rst_n = 1'b0;
    addr = '0; cs = 1'b0; we = 1'b0; oe = 1'b1; burst = 1'b0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: nothing driven after reset even with oe high
    @(negedge clk);
    check("R10 pipe enable", {7'd0, en_p}, 8'd0);
    check("R10 flow enable", {7'd0, en_f}, 8'd0);
    check("R10 pipe data", dout_p, '0);
    check("R10 flow data", dout_f, '0);

    // R2: plain writes, then R3/R4 read back including back-to-back write/read
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) cyc(AW'(16 + i), 1'b1, 1'b1, 1'b1, 1'b0, DW'(8'hA0 + i));
    cyc(AW'(16), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(AW'(24), 1'b1, 1'b1, 1'b1, 1'b0, 8'h5C);
    cyc(AW'(24), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) cyc(AW'(16 + i), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

    // R8 and R6: write burst at base 0x7A0 with junk on addr_i during beats
    cur_tag = "R8";
    cyc(11'h7A0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h11);
    cyc(11'h123, 1'b1, 1'b1, 1'b1, 1'b1, 8'h22);
    cyc(11'h456, 1'b1, 1'b1, 1'b1, 1'b1, 8'h33);
    cyc(11'h0FF, 1'b1, 1'b1, 1'b1, 1'b1, 8'h44);
    // R5: read burst starting at offset 2 wraps 2,3,0,1
    cur_tag = "R5";
    cyc(11'h7A2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(11'h3C1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    cyc(11'h001, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    cyc(11'h7FF, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    // R7: burst low loads a new address mid-group
    cur_tag = "R7";
    cyc(AW'(17), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(11'h7A3, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    // R11: write with chip select low leaves the word intact
    cur_tag = "R11";
    cyc(AW'(18), 1'b0, 1'b1, 1'b1, 1'b0, 8'hEE);
    cyc(AW'(18), 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(AW'(18), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    // R9: read with output enable low
    cur_tag = "R9";
    cyc(AW'(19), 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(AW'(20), 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(AW'(20), 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

    // R1: constrained random mix over a small window
    cur_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] ra;
      ra = {AW'($urandom_range(0, 15)) << 2} | AW'($urandom_range(0, 3));
      cyc(ra, ($urandom_range(0, 99) < 85), ($urandom_range(0, 99) < 40),
          ($urandom_range(0, 99) < 80), ($urandom_range(0, 99) < 40), DW'($urandom));
    end
    cyc('0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc('0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    check_outputs();
    summary();
  end
endmodule